// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a synchronous request port to an external asynchronous static RAM that holds 131,072 bytes. A client offers one byte-wide read or write at a time on a valid/ready handshake with a 17-bit address. The controller drives the memory address, a low-active and a high-active chip select, the output strobe and the write strobe. It handles the shared data bus through three separate signals: an outgoing byte, an incoming byte and a drive enable. Reads end with a one-cycle response pulse that carries the captured byte.

Every strobe phase lasts a whole number of system clocks. Each number comes from a nanosecond parameter divided by the clock period and rounded up, and it is never less than one. This covers the access time, the minimum cycle time, the write pulse width, the data-to-strobe overlap and the time the memory may keep driving the bus after it is deselected. With the default 5 ns clock and the 55 ns timing set, a read keeps the memory selected for 11 cycles. A write holds the write strobe low for 9 cycles, and a write that follows a read waits at least 6 idle bus cycles before the controller drives data.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is applied and right after it, sram_ce1_n is 1, sram_ce2 is 0, sram_oe_n is 1, sram_we_n is 1, sram_dq_oe is 0, rsp_valid is 0 and req_ready is 1.
- R2: req_ready is 1 only while the controller is idle. A request is taken on the rising edge where req_valid and req_ready are both 1, and req_ready stays 0 from that edge until the transaction is complete.
- R3: A read selects the memory (sram_ce1_n=0, sram_ce2=1) with sram_oe_n=0 and sram_we_n=1. This lasts RD = max(ceil(T_AA/P), ceil(T_RC/P)) cycles, where P is CLK_PERIOD_NS, and sram_addr holds the request address throughout. sram_dq_in is sampled on the edge that ends that window.
- R4: After a read, rsp_valid is 1 for exactly one cycle and rsp_rdata holds the byte stored at the address. The pulse starts RD clock edges after the accepting edge, so it is seen in the (RD+1)-th cycle counted from the accepting edge.
- R5: A write holds sram_we_n=0 for WP = max(ceil(T_WP/P), ceil(T_DW/P), ceil(T_RC/P)-2) consecutive cycles. During that time the memory is selected, sram_oe_n is 1, sram_dq_oe is 1, and sram_addr and sram_dq_out are stable. The byte is stored at the address when sram_we_n rises.
- R6: sram_dq_oe is 1 only while sram_we_n is 0 and for one cycle after it rises. sram_dq_out does not change in that extra cycle.
- R7: After a read, sram_dq_oe does not rise until sram_oe_n has been 1 for at least ceil(T_OHZ/P) full cycles.
- R8: sram_oe_n and sram_we_n are never 0 together. Whenever req_ready is 1, the memory is deselected, both strobes are 1 and sram_dq_oe is 0.
- R9: The full 17-bit address reaches sram_addr unchanged, including the corner addresses 0x00000 and 0x1FFFF.
- R10: A read returns the byte written most recently to the same address, including a read issued right after that write and a write issued right after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse when read data is valid |
| rsp_rdata | output | DATA_W | Byte captured by the last read |
| sram_addr | output | ADDR_W | Memory address bus |
| sram_ce1_n | output | 1 | Chip select, active low |
| sram_ce2 | output | 1 | Chip select, active high |
| sram_oe_n | output | 1 | Output strobe, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_dq_out | output | DATA_W | Byte driven onto the data bus |
| sram_dq_in | input | DATA_W | Byte read from the data bus |
| sram_dq_oe | output | 1 | Data bus drive enable |

## Verification
The assertions check four strobe rules on every cycle. The output and write strobes are never low together. The write strobe never falls without the memory selected. The drive enable stays inside its window around the write strobe, and the address is steady while the output strobe is low. They also check that the response is a single-cycle pulse, that the phase counter only counts down, and that the bus-release counter has expired whenever the drive enable rises. The bench's memory model is what shows the timing is met. It returns corrupted data when a read is sampled before the access count, it flags any overlap between its own drive tail and the controller's drive, and it measures the write pulse length, data stability and hold. Read latency, read-after-write values, corner addresses and the handshake are checked through the scenarios.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        IDLE       = 3'd0,
        RD_ACCESS  = 3'd1,
        RD_DONE    = 3'd2,
        WR_SETUP   = 3'd3,
        WR_PULSE   = 3'd4,
        WR_RECOVER = 3'd5,
        TURNAROUND = 3'd6
    } ctl_state_e;

    // Whole clock cycles covering t_ns, never fewer than one.
    function automatic int ns_to_cycles(input int t_ns, input int period_ns);
        int c;
        c = (t_ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R3
    tmr_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] bus_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } cap_regs_t;

    cap_regs_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = capture;
        if (capture) cap_d.data = bus_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rsp_valid = cap_q.vld;
    assign rsp_rdata = cap_q.data;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 5,
    parameter int T_RC          = 55,
    parameter int T_AA          = 55,
    parameter int T_WP          = 40,
    parameter int T_DW          = 25,
    parameter int T_OHZ         = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe
);

    localparam int RC_CYC  = ns_to_cycles(T_RC, CLK_PERIOD_NS);
    localparam int AA_CYC  = ns_to_cycles(T_AA, CLK_PERIOD_NS);
    localparam int WP_CYC  = ns_to_cycles(T_WP, CLK_PERIOD_NS);
    localparam int DW_CYC  = ns_to_cycles(T_DW, CLK_PERIOD_NS);
    localparam int OHZ_CYC = ns_to_cycles(T_OHZ, CLK_PERIOD_NS);
    // Read window covers access time and cycle time.
    localparam int RD_CYC  = imax(AA_CYC, RC_CYC);
    // Write pulse covers pulse width, data overlap and, with the setup and
    // recovery cycles around it, the minimum write cycle.
    localparam int WP_LEN  = imax(imax(WP_CYC, DW_CYC), imax(RC_CYC - 2, 1));
    localparam int MAX_CYC = imax(imax(RD_CYC, WP_LEN), OHZ_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LOAD  = CNT_W'(WP_LEN - 1);
    localparam logic [CNT_W-1:0] OHZ_LOAD = CNT_W'(OHZ_CYC - 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ce1_n;
        logic              ce2;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
    } ctl_regs_t;

    localparam ctl_regs_t CTL_RESET = '{
        st: IDLE, addr: '0, wdata: '0,
        ce1_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0
    };

    ctl_regs_t        r_d, r_q;
    logic             ph_load, hz_load, capture;
    logic [CNT_W-1:0] ph_val;
    logic             ph_zero, hz_zero;

    always_comb begin
        r_d     = r_q;
        ph_load = 1'b0;
        ph_val  = '0;
        hz_load = 1'b0;
        capture = 1'b0;
        case (r_q.st)
            IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    if (!req_write) begin
                        r_d.st    = RD_ACCESS;
                        r_d.ce1_n = 1'b0;
                        r_d.ce2   = 1'b1;
                        r_d.oe_n  = 1'b0;
                        ph_load   = 1'b1;
                        ph_val    = RD_LOAD;
                    end else if (hz_zero) begin
                        r_d.st    = WR_SETUP;
                        r_d.ce1_n = 1'b0;
                        r_d.ce2   = 1'b1;
                    end else begin
                        r_d.st    = TURNAROUND;
                    end
                end
            end
            TURNAROUND: begin
                if (hz_zero) begin
                    r_d.st    = WR_SETUP;
                    r_d.ce1_n = 1'b0;
                    r_d.ce2   = 1'b1;
                end
            end
            WR_SETUP: begin
                r_d.st    = WR_PULSE;
                r_d.we_n  = 1'b0;
                r_d.dq_oe = 1'b1;
                ph_load   = 1'b1;
                ph_val    = WP_LOAD;
            end
            WR_PULSE: begin
                if (ph_zero) begin
                    r_d.st   = WR_RECOVER;
                    r_d.we_n = 1'b1;
                end
            end
            WR_RECOVER: begin
                r_d.st    = IDLE;
                r_d.dq_oe = 1'b0;
                r_d.ce1_n = 1'b1;
                r_d.ce2   = 1'b0;
            end
            RD_ACCESS: begin
                if (ph_zero) begin
                    r_d.st    = RD_DONE;
                    r_d.ce1_n = 1'b1;
                    r_d.ce2   = 1'b0;
                    r_d.oe_n  = 1'b1;
                    capture   = 1'b1;
                    hz_load   = 1'b1;
                end
            end
            RD_DONE: begin
                r_d.st = IDLE;
            end
            default: begin
                r_d = CTL_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= CTL_RESET;
        else        r_q <= r_d;
    end

    sram_phase_timer #(.CNT_W(CNT_W)) i_phase_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    sram_phase_timer #(.CNT_W(CNT_W)) i_release_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (hz_load),
        .load_val (OHZ_LOAD),
        .zero     (hz_zero)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) i_rd_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .bus_in    (sram_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign req_ready   = (r_q.st == IDLE);
    assign sram_addr   = r_q.addr;
    assign sram_dq_out = r_q.wdata;
    assign sram_ce1_n  = r_q.ce1_n;
    assign sram_ce2    = r_q.ce2;
    assign sram_oe_n   = r_q.oe_n;
    assign sram_we_n   = r_q.we_n;
    assign sram_dq_oe  = r_q.dq_oe;

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_oe_n && !sram_we_n));

    // R5
    we_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n) |-> (!sram_ce1_n && sram_ce2 && sram_oe_n));

    // R6
    dq_oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> (!sram_we_n || $past(!sram_we_n)));

    // R7
    bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> hz_zero);

    // R3
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr));

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;
    localparam int P      = 5;

    function automatic int cyc(input int t);
        int c;
        c = (t + P - 1) / P;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int EXP_RD  = mx(cyc(55), cyc(55));
    localparam int EXP_WP  = mx(mx(cyc(40), cyc(25)), cyc(55) - 2);
    localparam int EXP_OHZ = cyc(30);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic [ADDR_W-1:0] sram_addr;
    logic              sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [DATA_W-1:0] sram_dq_out;
    logic [DATA_W-1:0] sram_dq_in;

    always #2.5 clk = ~clk;

    sram_async_ctrl i_sram_async_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .sram_addr   (sram_addr),
        .sram_ce1_n  (sram_ce1_n),
        .sram_ce2    (sram_ce2),
        .sram_oe_n   (sram_oe_n),
        .sram_we_n   (sram_we_n),
        .sram_dq_out (sram_dq_out),
        .sram_dq_in  (sram_dq_in),
        .sram_dq_oe  (sram_dq_oe)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] init_byte(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h3C;
    endfunction

    // ---------------- memory model ----------------
    logic [7:0] mem_m   [int];
    logic [7:0] exp_mem [int];

    function automatic logic [7:0] model_byte(input logic [16:0] a);
        if (mem_m.exists(int'(a))) return mem_m[int'(a)];
        return init_byte(a);
    endfunction

    function automatic logic [7:0] exp_byte(input logic [16:0] a);
        if (exp_mem.exists(int'(a))) return exp_mem[int'(a)];
        return init_byte(a);
    endfunction

    logic       drive_now;
    int         acc = 0;
    int         tail = 0;
    logic [7:0] rd_val = 8'h00;
    logic [16:0] acc_addr = '0;
    int         wp = 0;
    logic [16:0] w_addr = '0;
    logic [7:0] w_data = 8'h00;
    int         since_oe = 1000;
    logic       prev_we_low = 1'b0;
    logic       prev_dq_oe = 1'b0;

    assign drive_now  = !sram_ce1_n && sram_ce2 && !sram_oe_n && sram_we_n;
    assign sram_dq_in = drive_now ? ((acc >= EXP_RD) ? rd_val : ~rd_val)
                                  : ((tail != 0) ? 8'hA5 : 8'h00);

    always @(negedge clk) begin
        if (rst_n) begin
            // R7: no overlap with the memory's own drive tail
            if (sram_dq_oe && (drive_now || tail != 0))
                chk(1'b0, "R7", "bus contention", 1, 0);
            if (sram_dq_oe && !prev_dq_oe)
                chk(since_oe >= EXP_OHZ, "R7", "idle cycles before drive", since_oe, EXP_OHZ);
            // R8
            if (!sram_oe_n && !sram_we_n)
                chk(1'b0, "R8", "both strobes low", 0, 1);
            // R6
            if (sram_dq_oe && sram_we_n && !prev_we_low)
                chk(1'b0, "R6", "drive outside write window", 1, 0);
            // read side
            if (drive_now) begin
                if (acc > 0 && sram_addr != acc_addr)
                    chk(1'b0, "R3", "address moved during read", int'(sram_addr), int'(acc_addr));
                if (acc == 0) rd_val = model_byte(sram_addr);
                acc      = acc + 1;
                acc_addr = sram_addr;
                tail     = EXP_OHZ;
            end else begin
                acc = 0;
                if (tail > 0) tail = tail - 1;
            end
            // write side
            if (!sram_we_n) begin
                if (sram_ce1_n || !sram_ce2 || !sram_oe_n || !sram_dq_oe)
                    chk(1'b0, "R5", "strobes during write pulse", 0, 1);
                if (wp > 0 && (sram_addr != w_addr || sram_dq_out != w_data))
                    chk(1'b0, "R5", "addr/data moved in pulse", int'(sram_dq_out), int'(w_data));
                wp     = wp + 1;
                w_addr = sram_addr;
                w_data = sram_dq_out;
            end else if (wp > 0) begin
                chk(wp == EXP_WP, "R5", "write pulse cycles", wp, EXP_WP);
                chk(sram_dq_oe && sram_dq_out == w_data, "R6", "data hold after pulse",
                    int'(sram_dq_out), int'(w_data));
                mem_m[int'(w_addr)] = w_data;
                wp = 0;
            end
            since_oe    = sram_oe_n ? ((since_oe < 1000) ? since_oe + 1 : since_oe) : 0;
            prev_we_low = !sram_we_n;
            prev_dq_oe  = sram_dq_oe;
        end
    end

    // ---------------- driver tasks ----------------
    task automatic check_idle(input string tag);
        chk(req_ready && sram_ce1_n && !sram_ce2 && sram_oe_n && sram_we_n && !sram_dq_oe,
            "R8", {"standby strobes when idle ", tag},
            {req_ready, sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe}, 6'b110110);
    endtask

    task automatic do_read(input logic [16:0] a, input string tag);
        int  lat;
        bit  busy_ok;
        logic [7:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        busy_ok = 1'b1;
        if (sram_addr != a)
            chk(1'b0, "R9", "address on bus", int'(sram_addr), int'(a));
        while (!rsp_valid && lat < 200) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        e = exp_byte(a);
        chk(busy_ok && !req_ready, "R2", {"ready low during read ", tag}, int'(busy_ok), 1);
        chk(lat == EXP_RD + 1, "R4", {"read latency ", tag}, lat, EXP_RD + 1);
        chk(rsp_rdata == e, "R10", {"read data ", tag}, int'(rsp_rdata), int'(e));
        @(negedge clk);
        chk(!rsp_valid, "R4", {"single-cycle response ", tag}, int'(rsp_valid), 0);
        check_idle(tag);
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d, input string tag);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!req_ready && n < 200) begin
            @(negedge clk);
            n++;
            if (!sram_we_n && sram_addr != a)
                chk(1'b0, "R9", "write address on bus", int'(sram_addr), int'(a));
        end
        chk(n >= EXP_WP + 2, "R2", {"ready low for whole write ", tag}, n, EXP_WP + 2);
        exp_mem[int'(a)] = d;
        check_idle(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "R2", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [16:0] pool [8];
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: during reset
        chk({req_ready, rsp_valid, sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe}
            == 7'b1010110, "R1", "reset outputs",
            {req_ready, rsp_valid, sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe},
            7'b1010110);
        rst_n = 1'b1;
        @(negedge clk);
        chk({req_ready, rsp_valid, sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe}
            == 7'b1010110, "R1", "outputs after reset",
            {req_ready, rsp_valid, sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe},
            7'b1010110);

        // Directed corners
        do_read(17'h00000, "R9 addr 0 initial");
        do_write(17'h1FFFF, 8'hC3, "R9 top addr");     // write right after a read (R7)
        do_read(17'h1FFFF, "R10 read after write");
        do_write(17'h00000, 8'h5E, "R9 addr 0");
        do_write(17'h00001, 8'hFF, "back-to-back write");
        do_read(17'h00000, "R10 addr 0 readback");
        do_read(17'h00001, "R3 consecutive reads");
        do_write(17'h00001, 8'h00, "overwrite R10");
        do_read(17'h00001, "R10 overwrite readback");

        // Constrained random mix
        for (int i = 0; i < 8; i++) pool[i] = 17'($urandom);
        for (int i = 0; i < 300; i++) begin
            logic [16:0] a;
            a = ($urandom % 4 == 0) ? 17'($urandom) : pool[$urandom % 8];
            if ($urandom % 2 == 0) do_write(a, 8'($urandom), "random");
            else                   do_read(a, "random");
        end

        repeat (10) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule